// File: doc/BRIEF.md
# Embedded video sync code decoder

This block follows an 8-bit interleaved 4:2:2 standard-definition pixel stream that arrives one byte per clock. It recovers line and field timing from the stream itself, with no separate sync wires. Each line is framed by two 4-byte timing codes. Each code is an all-ones byte, two zero bytes and then a status byte. The status byte carries a field flag, a vertical-blanking flag and a horizontal-blanking flag, protected by four check bits. The end-of-active code comes first. Horizontal blanking follows, filled with alternating 0x80/0x10 bytes or ancillary data. Then comes the start-of-active code, followed by 1440 active samples in the order Cb, Y, Cr, Y.

From each code whose check bits are valid, the decoder takes the three flags and pulses a start-of-line or end-of-line strobe. It raises an active-video strobe with a running sample index during the picture part of each line. A status byte with bad check bits raises a protection error and is otherwise ignored. Each line's active length is compared with the expected count. The blanking length is compared with 268 bytes (525-line, 60 Hz) or 280 bytes (625-line, 50 Hz), chosen by a standard-select input. A mismatch raises an error pulse.

Top module: `sync_code_decoder`

## Requirements
- R1: A status byte is recognised only when the three bytes before it were 0xFF, 0x00, 0x00. One clock after a valid status byte, field_id, vblank and hblank take its bits 6, 5 and 4. They hold those values until the next valid status byte.
- R2: A status byte is valid when bit 7 is 1 and bits 3,2,1,0 equal V^H, F^H, F^V, F^V^H. If it is invalid, prot_err is high for one clock and the flags keep their values. No line_start or line_end pulse follows. For counting, the byte counts as an ordinary byte.
- R3: A valid status byte with H=0 (start of active video) gives a one-clock line_start pulse one clock later. One with H=1 (end of active video) gives a one-clock line_end pulse instead.
- R4: A start code with V=0 is followed by ACTIVE_LEN (1440) bytes. One clock after each of them, vid_active is high and pix_idx counts up from 0. vid_active is low for later bytes and for every valid code.
- R5: After a start code with V=1, vid_active stays low for the whole line.
- R6: len_err pulses together with line_end when the bytes strictly between the start status byte and the end status byte number something other than ACTIVE_LEN+3. It is never raised for an end code that has no start code since reset or since the previous end code.
- R7: blank_err pulses together with line_start when the bytes strictly between the end status byte and the start status byte number something other than the blanking length plus 3. The blanking length is 268 when std_625=0 and 280 when std_625=1. It is never raised for a start code that has no end code before it.
- R8: While rst is high and on the clock after it falls, all outputs are low and no line or blanking interval is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| std_625 | input | 1 | 1 selects the 625-line blanking length, 0 the 525-line length |
| din | input | 8 | Incoming stream byte |
| vid_active | output | 1 | High for each active picture byte |
| pix_idx | output | 11 | Index of the active byte within the line |
| line_start | output | 1 | Pulse after a valid start-of-active code |
| line_end | output | 1 | Pulse after a valid end-of-active code |
| field_id | output | 1 | Field flag from the last valid code |
| vblank | output | 1 | Vertical-blanking flag from the last valid code |
| hblank | output | 1 | Horizontal-blanking flag from the last valid code |
| prot_err | output | 1 | Pulse for a status byte with bad check bits |
| len_err | output | 1 | Pulse when the active length of a line is wrong |
| blank_err | output | 1 | Pulse when the blanking length is wrong |

## Verification
The stream contains well-formed 525-line and 625-line lines, and these show whether the strobe and index line up with the codes. A short line and a long line are followed by correct ones, which separates a true length check from a counter that only saturates. A blanking gap of the other standard's length, sent under each setting of std_625, shows that the select input really chooses the limit. A line flagged as vertical blanking, a code with a flipped check bit placed inside blanking, and a reset in the middle of a line test flag hold, error isolation and reset clearing.

// File: rtl/sync_code_pkg.sv
`timescale 1ns/1ps
package sync_code_pkg;
    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } flags_t;

    // Check bits in order bit3..bit0
    function automatic logic [3:0] prot_bits(input flags_t fl);
        return {fl.v ^ fl.h, fl.f ^ fl.h, fl.f ^ fl.v, fl.f ^ fl.v ^ fl.h};
    endfunction
endpackage

// File: rtl/sync_preamble_det.sv
`timescale 1ns/1ps
module sync_preamble_det #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic              hit
);
    localparam logic [DATA_W-1:0] ALL_ONE  = '1;
    localparam logic [DATA_W-1:0] ALL_ZERO = '0;

    typedef struct packed {
        logic [DATA_W-1:0] b2;
        logic [DATA_W-1:0] b1;
        logic [DATA_W-1:0] b0;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d    = hist_q;
        hist_d.b2 = hist_q.b1;
        hist_d.b1 = hist_q.b0;
        hist_d.b0 = din;
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end

    // The current byte is a status byte when the three before it form the preamble
    assign hit = (hist_q.b2 == ALL_ONE) && (hist_q.b1 == ALL_ZERO) && (hist_q.b0 == ALL_ZERO);
endmodule

// File: rtl/sync_status_check.sv
`timescale 1ns/1ps
module sync_status_check
    import sync_code_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] sbyte,
    output flags_t            flags,
    output logic              valid
);
    assign flags.f = sbyte[DATA_W-2];
    assign flags.v = sbyte[DATA_W-3];
    assign flags.h = sbyte[DATA_W-4];
    assign valid   = sbyte[DATA_W-1] && (sbyte[DATA_W-5 -: 4] == prot_bits(flags));
endmodule

// File: rtl/sync_line_timer.sv
`timescale 1ns/1ps
module sync_line_timer #(
    parameter int ACTIVE_LEN = 1440,
    parameter int BLANK_525  = 268,
    parameter int BLANK_625  = 280,
    localparam int IDX_W     = $clog2(ACTIVE_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             std_625,
    input  logic             code_ok,
    input  logic             code_end,
    input  logic             code_v,
    output logic             act,
    output logic [IDX_W-1:0] idx,
    output logic             len_err,
    output logic             blank_err
);
    localparam int PRE_LEN = 3;
    localparam int CNT_W   = $clog2(ACTIVE_LEN + BLANK_625 + 8) + 1;
    localparam logic [CNT_W-1:0] ACT_C    = CNT_W'(ACTIVE_LEN);
    localparam logic [CNT_W-1:0] LINE_T   = CNT_W'(ACTIVE_LEN + PRE_LEN);
    localparam logic [CNT_W-1:0] B525_T   = CNT_W'(BLANK_525 + PRE_LEN);
    localparam logic [CNT_W-1:0] B625_T   = CNT_W'(BLANK_625 + PRE_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        logic             in_line;
        logic             line_v;
        logic             in_blank;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] bcnt;
        logic             act;
        logic [IDX_W-1:0] idx;
        logic             len_err;
        logic             blank_err;
    } tstate_t;

    tstate_t st_d, st_q;
    logic [CNT_W-1:0] blank_target;

    always_comb begin
        st_d           = st_q;
        st_d.act       = 1'b0;
        st_d.len_err   = 1'b0;
        st_d.blank_err = 1'b0;
        blank_target   = std_625 ? B625_T : B525_T;
        if (code_ok) begin
            if (code_end) begin
                st_d.len_err  = st_q.in_line && (st_q.cnt != LINE_T);
                st_d.in_line  = 1'b0;
                st_d.in_blank = 1'b1;
                st_d.bcnt     = '0;
            end else begin
                st_d.blank_err = st_q.in_blank && (st_q.bcnt != blank_target);
                st_d.in_blank  = 1'b0;
                st_d.in_line   = 1'b1;
                st_d.cnt       = '0;
                st_d.line_v    = code_v;
            end
        end else begin
            st_d.act = st_q.in_line && !st_q.line_v && (st_q.cnt < ACT_C);
            if (st_d.act) st_d.idx = st_q.cnt[IDX_W-1:0];
            if (st_q.in_line && (st_q.cnt != CNT_MAX))   st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.in_blank && (st_q.bcnt != CNT_MAX)) st_d.bcnt = st_q.bcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign act       = st_q.act;
    assign idx       = st_q.idx;
    assign len_err   = st_q.len_err;
    assign blank_err = st_q.blank_err;

    // R4: the index stays inside the active window
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
        act |-> (idx < IDX_W'(ACTIVE_LEN)));

    // R4: consecutive active bytes carry consecutive indices
    assert_idx_step_R4: assert property (@(posedge clk) disable iff (rst)
        (act && $past(act)) |-> (idx == IDX_W'($past(idx) + 1'b1)));
endmodule

// File: rtl/sync_code_decoder.sv
`timescale 1ns/1ps
module sync_code_decoder
    import sync_code_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ACTIVE_LEN = 1440,
    parameter int BLANK_525  = 268,
    parameter int BLANK_625  = 280,
    localparam int IDX_W     = $clog2(ACTIVE_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              std_625,
    input  logic [DATA_W-1:0] din,
    output logic              vid_active,
    output logic [IDX_W-1:0]  pix_idx,
    output logic              line_start,
    output logic              line_end,
    output logic              field_id,
    output logic              vblank,
    output logic              hblank,
    output logic              prot_err,
    output logic              len_err,
    output logic              blank_err
);
    typedef struct packed {
        flags_t flags;
        logic   sol;
        logic   eol;
        logic   perr;
    } top_state_t;

    top_state_t ts_d, ts_q;
    logic   hit;
    logic   stat_ok;
    flags_t stat_fl;
    logic   code_ok;

    sync_preamble_det #(.DATA_W(DATA_W)) u_det (
        .clk (clk),
        .rst (rst),
        .din (din),
        .hit (hit)
    );

    sync_status_check #(.DATA_W(DATA_W)) u_chk (
        .sbyte (din),
        .flags (stat_fl),
        .valid (stat_ok)
    );

    assign code_ok = hit && stat_ok;

    sync_line_timer #(
        .ACTIVE_LEN (ACTIVE_LEN),
        .BLANK_525  (BLANK_525),
        .BLANK_625  (BLANK_625)
    ) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .std_625   (std_625),
        .code_ok   (code_ok),
        .code_end  (stat_fl.h),
        .code_v    (stat_fl.v),
        .act       (vid_active),
        .idx       (pix_idx),
        .len_err   (len_err),
        .blank_err (blank_err)
    );

    always_comb begin
        ts_d      = ts_q;
        ts_d.sol  = 1'b0;
        ts_d.eol  = 1'b0;
        ts_d.perr = hit && !stat_ok;
        if (code_ok) begin
            ts_d.flags = stat_fl;
            ts_d.sol   = !stat_fl.h;
            ts_d.eol   = stat_fl.h;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ts_q <= '0;
        else     ts_q <= ts_d;
    end

    assign field_id   = ts_q.flags.f;
    assign vblank     = ts_q.flags.v;
    assign hblank     = ts_q.flags.h;
    assign line_start = ts_q.sol;
    assign line_end   = ts_q.eol;
    assign prot_err   = ts_q.perr;

    // R3: a single code never gives both strobes
    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !(line_start && line_end));

    // R2: a rejected status byte leaves the flags and strobes alone
    assert_prot_hold_R2: assert property (@(posedge clk) disable iff (rst)
        prot_err |-> ($stable({field_id, vblank, hblank}) && !line_start && !line_end));

    // R6: length errors are reported only with an end strobe
    assert_len_with_end_R6: assert property (@(posedge clk) disable iff (rst)
        len_err |-> line_end);

    // R7: blanking errors are reported only with a start strobe
    assert_blank_with_start_R7: assert property (@(posedge clk) disable iff (rst)
        blank_err |-> line_start);

    // R5: no active bytes while vertical blanking is flagged
    assert_no_act_vblank_R5: assert property (@(posedge clk) disable iff (rst)
        vid_active |-> !vblank);

    // R4: the active strobe only begins right after a start strobe
    assert_act_after_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(vid_active) |-> $past(line_start));
endmodule

// File: tb/tb_sync_code_decoder.sv
`timescale 1ns/1ps
module tb_sync_code_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        std_625 = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        vid_active, line_start, line_end, field_id, vblank, hblank;
    logic        prot_err, len_err, blank_err;
    logic [10:0] pix_idx;

    always #2.5 clk = ~clk;

    sync_code_decoder dut (
        .clk(clk), .rst(rst), .std_625(std_625), .din(din),
        .vid_active(vid_active), .pix_idx(pix_idx),
        .line_start(line_start), .line_end(line_end),
        .field_id(field_id), .vblank(vblank), .hblank(hblank),
        .prot_err(prot_err), .len_err(len_err), .blank_err(blank_err)
    );

    typedef struct {
        logic        act;
        logic [10:0] idx;
        logic        sol, eol, f, v, h, perr, lerr, berr;
        bit          rej;
        bit          lv;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    // Bench model of the timing state, built from the requirements
    logic m_f, m_v, m_h, m_in_line, m_line_v, m_in_blank;
    int   m_cnt, m_bcnt;

    task automatic chk(input string req, input string what, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, actual, expected, $time);
        end
    endtask

    task automatic model_reset();
        m_f = 0; m_v = 0; m_h = 0; m_in_line = 0; m_line_v = 0; m_in_blank = 0;
        m_cnt = 0; m_bcnt = 0;
    endtask

    function automatic bit status_ok(input logic [7:0] b);
        return b[7] && (b[3:0] == {b[5]^b[4], b[6]^b[4], b[6]^b[5], b[6]^b[5]^b[4]});
    endfunction

    function automatic logic [7:0] mk_status(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v^h, f^h, f^v, f^v^h};
    endfunction

    // Driver: sends one byte and queues what the outputs must show after it
    task automatic put_byte(input logic [7:0] b, input bit is_code);
        exp_t e;
        e = '{act:0, idx:0, sol:0, eol:0, f:0, v:0, h:0, perr:0, lerr:0, berr:0, rej:0, lv:0};
        @(negedge clk);
        din = b;
        if (is_code && status_ok(b)) begin
            m_f = b[6]; m_v = b[5]; m_h = b[4];
            if (b[4]) begin
                e.eol = 1;
                e.lerr = m_in_line && (m_cnt != 1443);
                m_in_line = 0; m_in_blank = 1; m_bcnt = 0;
            end else begin
                e.sol = 1;
                e.berr = m_in_blank && (m_bcnt != (std_625 ? 283 : 271));
                m_in_blank = 0; m_in_line = 1; m_cnt = 0; m_line_v = b[5];
            end
        end else begin
            e.perr = is_code;
            e.rej  = is_code;
            e.act  = m_in_line && !m_line_v && (m_cnt < 1440);
            e.idx  = 11'(m_cnt);
            if (m_in_line)  m_cnt++;
            if (m_in_blank) m_bcnt++;
        end
        e.lv = m_in_line && m_line_v;
        e.f = m_f; e.v = m_v; e.h = m_h;
        exp_q.push_back(e);
    endtask

    task automatic send_code(input logic f, input logic v, input logic h, input bit corrupt);
        logic [7:0] s;
        put_byte(8'hFF, 0);
        put_byte(8'h00, 0);
        put_byte(8'h00, 0);
        s = mk_status(f, v, h);
        if (corrupt) s[1] = ~s[1];
        put_byte(s, 1);
    endtask

    task automatic send_line(input logic f, input logic v, input int blank_n,
                             input int active_n, input bit bad_code);
        int fill;
        send_code(f, v, 1'b1, 0);
        fill = bad_code ? blank_n - 4 : blank_n;
        for (int i = 0; i < fill; i++) begin
            put_byte((i % 2 == 0) ? 8'h80 : 8'h10, 0);
            if (bad_code && i == fill / 2) send_code(~f, ~v, 1'b0, 1);
        end
        send_code(f, v, 1'b0, 0);
        for (int i = 0; i < active_n; i++) put_byte(8'(8'h10 + (i % 200)), 0);
    endtask

    // Monitor: compares each queued expectation one clock after its byte
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                if (e.lv) chk("R5", "vid_active", vid_active, e.act);
                else      chk("R4", "vid_active", vid_active, e.act);
                if (e.act) chk("R4", "pix_idx", pix_idx, e.idx);
                chk(e.rej ? "R2" : "R3", "line_start", line_start, e.sol);
                chk(e.rej ? "R2" : "R3", "line_end", line_end, e.eol);
                chk(e.rej ? "R2" : "R1", "field_id", field_id, e.f);
                chk(e.rej ? "R2" : "R1", "vblank", vblank, e.v);
                chk(e.rej ? "R2" : "R1", "hblank", hblank, e.h);
                chk("R2", "prot_err", prot_err, e.perr);
                chk("R6", "len_err", len_err, e.lerr);
                chk("R7", "blank_err", blank_err, e.berr);
            end
        end
    end

    task automatic check_reset_outputs();
        chk("R8", "vid_active", vid_active, 0);
        chk("R8", "line_start", line_start, 0);
        chk("R8", "line_end", line_end, 0);
        chk("R8", "flags", {field_id, vblank, hblank}, 0);
        chk("R8", "errors", {prot_err, len_err, blank_err}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        check_reset_outputs();
        rst = 0;
        @(negedge clk);
        check_reset_outputs();

        std_625 = 0;
        send_line(0, 0, 268, 1440, 0);   // first end code after reset: no R6 error
        send_line(0, 0, 268, 1440, 0);   // clean 525-line line
        send_line(0, 0, 268, 1436, 0);   // short active part
        send_line(0, 0, 270, 1440, 0);   // R6 error on end, R7 error on start
        send_line(0, 1, 268, 1440, 0);   // vertical blanking line (R5)
        send_line(1, 0, 268, 1440, 1);   // rejected code inside blanking (R2)
        std_625 = 1;
        send_line(1, 0, 280, 1440, 0);   // clean 625-line gap
        send_line(1, 0, 268, 1440, 0);   // 525 gap under 625 selection (R7)
        send_line(1, 0, 280, 1444, 0);   // long active part
        send_line(0, 0, 280, 1440, 0);   // R6 error for the long line
        std_625 = 0;
        send_line(0, 0, 268, 1440, 0);
        send_code(0, 0, 1'b1, 0);
        send_code(0, 0, 1'b0, 0);
        for (int i = 0; i < 100; i++) put_byte(8'h40, 0);

        // Reset in the middle of a line (R8)
        @(negedge clk);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        check_reset_outputs();
        rst = 0;
        model_reset();
        @(negedge clk);
        check_reset_outputs();
        for (int i = 0; i < 20; i++) put_byte(8'h50, 0);  // no line in progress
        send_code(1, 0, 1'b0, 0);                          // start without end: no R7 error
        for (int i = 0; i < 8; i++) put_byte(8'h60, 0);
        @(negedge clk);
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule